// File: doc/BRIEF.md
# Tracklet Straight-Line Fit Sum Accumulator

This block collects, during the drift time of one event, the running sums that a processor later needs for a least-squares straight-line fit of charge clusters. In each timebin it receives one filtered amplitude per channel. It treats every channel that has a neighbour on both sides as the centre of a three-channel group, and it flags a hit where that centre forms a local peak carrying enough charge. For each hit it computes a signed centre-of-gravity fraction. It then adds the timebin index, the fraction and their products into the fit unit that belongs to that centre channel.

The fit units are shared by the channels that first produce a hit in the event. Candidates within a timebin are taken one after another through a single shared multi-cycle divider. The block reports that it is busy until the whole timebin has been absorbed. A pulse at event start clears everything. The accumulated values leave the block only through a combinational read port, which has no write path.

Top module: `tracklet_fit_accum`

## Requirements
- R1: A group centred on channel c (1 <= c <= NUM_CH-2) is a hit when its amplitude is strictly greater than both neighbours and the three-channel sum L+C+R is strictly greater than `thr_i`. Channels 0 and NUM_CH-1 are never centres.
- R2: The hits of one timebin are taken in ascending centre order. At most MAX_CAND (4) of them are processed and the rest are dropped.
- R3: A candidate whose centre channel already owns a unit adds to that unit. Otherwise it takes the lowest-numbered unallocated unit. When all units are allocated it is discarded, but it still counts toward the MAX_CAND limit.
- R4: The position is y = (R-L)*2^FRAC_W/(L+C+R), truncated toward zero and held as a FRAC_W+1 bit signed value.
- R5: Each unit keeps the hit count N and the sums of x, y, x*y, x*x, y*y and Q. Here x is the timebin index counted from 0 at event start and Q = L+C+R.
- R6: N, Σx, Σx², Σy² and ΣQ are unsigned and clamp at 2^ACC_W-1. Σy and Σxy are two's complement and clamp at their most positive or most negative value. Any clamp sets a per-unit overflow flag, which stays set until event start.
- R7: `event_start_i` clears all sums, overflow flags, unit allocations and the timebin index, and it aborts a timebin in progress.
- R8: Once 2^TB_W timebins have been accepted, further `tb_valid_i` pulses have no effect. A `tb_valid_i` pulse that arrives while `busy_o` is high is also ignored.
- R9: `rd_data_o` follows `rd_unit_i` and `rd_sel_i` combinationally. The select codes are: 0 = N, 1 = Σx, 2 = Σy, 3 = Σxy, 4 = Σx², 5 = Σy², 6 = ΣQ, 7 = status. In the status word, bit 0 is the overflow flag, bit 1 is the allocated flag, and bits [2+:CH_W] hold the owning channel.
- R10: `busy_o` is high in the cycle after an accepted `tb_valid_i`. It stays high for no more than MAX_CAND*(FRAC_W+3)+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| event_start_i | input | 1 | Clears the block for a new event |
| tb_valid_i | input | 1 | Presents the samples of one timebin |
| samples_i | input | NUM_CH*SAMPLE_W | Channel amplitudes, channel i at [i*SAMPLE_W +: SAMPLE_W] |
| thr_i | input | SAMPLE_W+2 | Three-channel charge threshold |
| rd_unit_i | input | clog2(NUM_UNITS) | Fit unit to read |
| rd_sel_i | input | 3 | Quantity to read (see R9) |
| rd_data_o | output | ACC_W | Selected sum or status word |
| busy_o | output | 1 | Timebin processing in progress |

## Verification
The hardest situations to reach are those that need long histories: the clamp of signed and unsigned sums, the refusal of the timebin after the last allowed one, and a candidate that finds every unit already taken. The stimulus gets to the clamps with a full 64-timebin event in a narrow-accumulator configuration, using two strong peaks whose positions have opposite signs. It exhausts the units by spreading five peaks over two timebins. A randomised sweep of events with different thresholds then compares every register of every unit after each timebin against an arithmetic model.

// File: rtl/fit_accum_pkg.sv
package fit_accum_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_DIV  = 2'd2,
        ST_ACC  = 2'd3
    } scan_state_e;

    localparam int SEL_W    = 3;
    localparam int SEL_N    = 0;
    localparam int SEL_SX   = 1;
    localparam int SEL_SY   = 2;
    localparam int SEL_SXY  = 3;
    localparam int SEL_SX2  = 4;
    localparam int SEL_SY2  = 5;
    localparam int SEL_SQ   = 6;
    localparam int SEL_STAT = 7;

endpackage

// File: rtl/fit_hit_finder.sv
module fit_hit_finder #(
    parameter int NUM_CH   = 12,
    parameter int SAMPLE_W = 10,
    parameter int SUM_W    = 12
) (
    input  logic [NUM_CH*SAMPLE_W-1:0] samples_i,
    input  logic [SUM_W-1:0]           thr_i,
    output logic [NUM_CH-1:0]          hit_o
);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_grp
        if (g == 0 || g == NUM_CH - 1) begin : g_edge
            assign hit_o[g] = 1'b0;
        end else begin : g_mid
            logic [SAMPLE_W-1:0] amp_l, amp_c, amp_r;
            logic [SUM_W-1:0]    grp_sum;
            assign amp_l   = samples_i[(g-1)*SAMPLE_W +: SAMPLE_W];
            assign amp_c   = samples_i[g*SAMPLE_W     +: SAMPLE_W];
            assign amp_r   = samples_i[(g+1)*SAMPLE_W +: SAMPLE_W];
            assign grp_sum = SUM_W'(amp_l) + SUM_W'(amp_c) + SUM_W'(amp_r);
            assign hit_o[g] = (amp_c > amp_l) && (amp_c > amp_r) && (grp_sum > thr_i);
        end
    end

endmodule

// File: rtl/fit_cog_divider.sv
module fit_cog_divider #(
    parameter int NUM_W = 10,
    parameter int DEN_W = 12,
    parameter int QUO_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [NUM_W-1:0] num_i,
    input  logic [DEN_W-1:0] den_i,
    output logic             done_o,
    output logic [QUO_W-1:0] quo_o
);

    localparam int CNT_W = $clog2(QUO_W + 1);

    typedef struct packed {
        logic [DEN_W:0]   rem;
        logic [DEN_W-1:0] den;
        logic [QUO_W-1:0] quo;
        logic [CNT_W-1:0] cnt;
        logic             run;
        logic             done;
    } div_s;

    div_s div_d, div_q;
    logic [DEN_W:0] shifted;
    logic           take;

    always_comb begin
        div_d      = div_q;
        div_d.done = 1'b0;
        shifted    = {div_q.rem[DEN_W-1:0], 1'b0};
        take       = shifted >= {1'b0, div_q.den};
        if (start_i) begin
            div_d.rem = (DEN_W+1)'(num_i);
            div_d.den = den_i;
            div_d.quo = '0;
            div_d.cnt = CNT_W'(QUO_W);
            div_d.run = 1'b1;
        end else if (div_q.run) begin
            div_d.rem = take ? (shifted - {1'b0, div_q.den}) : shifted;
            div_d.quo = QUO_W'({div_q.quo, take});
            div_d.cnt = div_q.cnt - 1'b1;
            if (div_q.cnt == CNT_W'(1)) begin
                div_d.run  = 1'b0;
                div_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign done_o = div_q.done;
    assign quo_o  = div_q.quo;

endmodule

// File: rtl/fit_sum_unit.sv
module fit_sum_unit #(
    parameter int ACC_W = 24,
    parameter int TB_W  = 6,
    parameter int POS_W = 7,
    parameter int SUM_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr_i,
    input  logic                    add_i,
    input  logic [TB_W-1:0]         x_i,
    input  logic signed [POS_W-1:0] y_i,
    input  logic [SUM_W-1:0]        q_i,
    output logic [ACC_W-1:0]        n_o,
    output logic [ACC_W-1:0]        sx_o,
    output logic [ACC_W-1:0]        sy_o,
    output logic [ACC_W-1:0]        sxy_o,
    output logic [ACC_W-1:0]        sx2_o,
    output logic [ACC_W-1:0]        sy2_o,
    output logic [ACC_W-1:0]        sq_o,
    output logic                    ovf_o
);

    localparam int XY_W = TB_W + POS_W + 1;

    typedef struct packed {
        logic [ACC_W-1:0] n;
        logic [ACC_W-1:0] sx;
        logic [ACC_W-1:0] sy;
        logic [ACC_W-1:0] sxy;
        logic [ACC_W-1:0] sx2;
        logic [ACC_W-1:0] sy2;
        logic [ACC_W-1:0] sq;
        logic             ovf;
    } acc_s;

    acc_s acc_d, acc_q;

    function automatic logic [ACC_W:0] sat_add_u(input logic [ACC_W-1:0] a, input logic [ACC_W-1:0] b);
        logic [ACC_W:0] t;
        t = {1'b0, a} + {1'b0, b};
        if (t[ACC_W]) return {1'b1, {ACC_W{1'b1}}};
        return t;
    endfunction

    function automatic logic [ACC_W:0] sat_add_s(input logic [ACC_W-1:0] a, input logic [ACC_W-1:0] b);
        logic [ACC_W:0] t;
        t = {a[ACC_W-1], a} + {b[ACC_W-1], b};
        if (t[ACC_W] != t[ACC_W-1]) return {1'b1, t[ACC_W], {(ACC_W-1){~t[ACC_W]}}};
        return {1'b0, t[ACC_W-1:0]};
    endfunction

    logic signed [XY_W-1:0]    xy_prod;
    logic signed [2*POS_W-1:0] yy_prod;
    logic [2*TB_W-1:0]         xx_prod;
    logic [ACC_W-1:0]          inc_x, inc_y, inc_xy, inc_xx, inc_yy, inc_q;
    logic [ACC_W:0]            r_n, r_sx, r_sy, r_sxy, r_sx2, r_sy2, r_sq;

    always_comb begin
        xy_prod = $signed({1'b0, x_i}) * y_i;
        yy_prod = y_i * y_i;
        xx_prod = x_i * x_i;
        inc_x   = ACC_W'(x_i);
        inc_y   = {{(ACC_W-POS_W){y_i[POS_W-1]}}, y_i};
        inc_xy  = {{(ACC_W-XY_W){xy_prod[XY_W-1]}}, xy_prod};
        inc_xx  = ACC_W'(xx_prod);
        inc_yy  = ACC_W'($unsigned(yy_prod));
        inc_q   = ACC_W'(q_i);

        r_n   = sat_add_u(acc_q.n,   ACC_W'(1));
        r_sx  = sat_add_u(acc_q.sx,  inc_x);
        r_sy  = sat_add_s(acc_q.sy,  inc_y);
        r_sxy = sat_add_s(acc_q.sxy, inc_xy);
        r_sx2 = sat_add_u(acc_q.sx2, inc_xx);
        r_sy2 = sat_add_u(acc_q.sy2, inc_yy);
        r_sq  = sat_add_u(acc_q.sq,  inc_q);

        acc_d = acc_q;
        if (clr_i) begin
            acc_d = '0;
        end else if (add_i) begin
            acc_d.n   = r_n[ACC_W-1:0];
            acc_d.sx  = r_sx[ACC_W-1:0];
            acc_d.sy  = r_sy[ACC_W-1:0];
            acc_d.sxy = r_sxy[ACC_W-1:0];
            acc_d.sx2 = r_sx2[ACC_W-1:0];
            acc_d.sy2 = r_sy2[ACC_W-1:0];
            acc_d.sq  = r_sq[ACC_W-1:0];
            acc_d.ovf = acc_q.ovf | r_n[ACC_W] | r_sx[ACC_W] | r_sy[ACC_W] | r_sxy[ACC_W]
                      | r_sx2[ACC_W] | r_sy2[ACC_W] | r_sq[ACC_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign n_o   = acc_q.n;
    assign sx_o  = acc_q.sx;
    assign sy_o  = acc_q.sy;
    assign sxy_o = acc_q.sxy;
    assign sx2_o = acc_q.sx2;
    assign sy2_o = acc_q.sy2;
    assign sq_o  = acc_q.sq;
    assign ovf_o = acc_q.ovf;

endmodule

// File: rtl/tracklet_fit_accum.sv
module tracklet_fit_accum
    import fit_accum_pkg::*;
#(
    parameter int NUM_CH    = 12,
    parameter int SAMPLE_W  = 10,
    parameter int NUM_UNITS = 4,
    parameter int MAX_CAND  = 4,
    parameter int TB_W      = 6,
    parameter int FRAC_W    = 6,
    parameter int ACC_W     = 24,
    localparam int SUM_W    = SAMPLE_W + 2,
    localparam int UNIT_W   = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       event_start_i,
    input  logic                       tb_valid_i,
    input  logic [NUM_CH*SAMPLE_W-1:0] samples_i,
    input  logic [SUM_W-1:0]           thr_i,
    input  logic [UNIT_W-1:0]          rd_unit_i,
    input  logic [SEL_W-1:0]           rd_sel_i,
    output logic [ACC_W-1:0]           rd_data_o,
    output logic                       busy_o
);

    localparam int POS_W  = FRAC_W + 1;
    localparam int CH_W   = $clog2(NUM_CH);
    localparam int CAND_W = $clog2(MAX_CAND + 1);
    localparam int NUM_TB = 2 ** TB_W;

    typedef struct packed {
        scan_state_e                 st;
        logic [NUM_CH*SAMPLE_W-1:0]  samp;
        logic [NUM_CH-1:0]           pend;
        logic [TB_W-1:0]             x;
        logic [TB_W:0]               tb_cnt;
        logic [CAND_W-1:0]           cand;
        logic [UNIT_W-1:0]           unit;
        logic                        neg;
        logic [SUM_W-1:0]            qsum;
        logic [NUM_UNITS-1:0]        alloc;
        logic [NUM_UNITS*CH_W-1:0]   unit_ch;
    } ctl_s;

    ctl_s ctl_d, ctl_q;

    logic [NUM_CH-1:0]       hit_now;
    logic                    div_start, div_done;
    logic [SAMPLE_W-1:0]     div_num;
    logic [SUM_W-1:0]        div_den;
    logic [FRAC_W-1:0]       div_quo;
    logic [NUM_UNITS-1:0]    add_vec;
    logic                    clr;
    logic signed [POS_W-1:0] y_acc;

    logic                    pick_vld;
    logic [CH_W-1:0]         pick_idx;
    logic [SAMPLE_W-1:0]     pick_l, pick_c, pick_r;
    logic                    pick_neg;
    logic [SAMPLE_W-1:0]     pick_num;
    logic [SUM_W-1:0]        pick_sum;
    logic                    match_vld, free_vld, go;
    logic [UNIT_W-1:0]       match_idx, free_idx;

    fit_hit_finder #(
        .NUM_CH   (NUM_CH),
        .SAMPLE_W (SAMPLE_W),
        .SUM_W    (SUM_W)
    ) u_hits (
        .samples_i (samples_i),
        .thr_i     (thr_i),
        .hit_o     (hit_now)
    );

    fit_cog_divider #(
        .NUM_W (SAMPLE_W),
        .DEN_W (SUM_W),
        .QUO_W (FRAC_W)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (div_start),
        .num_i   (div_num),
        .den_i   (div_den),
        .done_o  (div_done),
        .quo_o   (div_quo)
    );

    // lowest pending centre and its three amplitudes
    always_comb begin
        pick_vld = 1'b0;
        pick_idx = '0;
        pick_l   = '0;
        pick_c   = '0;
        pick_r   = '0;
        for (int i = 1; i < NUM_CH - 1; i++) begin
            if (ctl_q.pend[i] && !pick_vld) begin
                pick_vld = 1'b1;
                pick_idx = CH_W'(i);
                pick_l   = ctl_q.samp[(i-1)*SAMPLE_W +: SAMPLE_W];
                pick_c   = ctl_q.samp[i*SAMPLE_W     +: SAMPLE_W];
                pick_r   = ctl_q.samp[(i+1)*SAMPLE_W +: SAMPLE_W];
            end
        end
        pick_neg = pick_r < pick_l;
        pick_num = pick_neg ? (pick_l - pick_r) : (pick_r - pick_l);
        pick_sum = SUM_W'(pick_l) + SUM_W'(pick_c) + SUM_W'(pick_r);
    end

    // unit lookup by centre channel, and lowest free unit
    always_comb begin
        match_vld = 1'b0;
        match_idx = '0;
        free_vld  = 1'b0;
        free_idx  = '0;
        for (int u = 0; u < NUM_UNITS; u++) begin
            if (ctl_q.alloc[u] && ctl_q.unit_ch[u*CH_W +: CH_W] == pick_idx && !match_vld) begin
                match_vld = 1'b1;
                match_idx = UNIT_W'(u);
            end
            if (!ctl_q.alloc[u] && !free_vld) begin
                free_vld = 1'b1;
                free_idx = UNIT_W'(u);
            end
        end
    end

    always_comb begin
        ctl_d     = ctl_q;
        clr       = 1'b0;
        div_start = 1'b0;
        div_num   = pick_num;
        div_den   = pick_sum;
        add_vec   = '0;
        go        = 1'b0;
        case (ctl_q.st)
            ST_IDLE: begin
                if (tb_valid_i && ctl_q.tb_cnt < (TB_W+1)'(NUM_TB)) begin
                    ctl_d.samp   = samples_i;
                    ctl_d.pend   = hit_now;
                    ctl_d.x      = ctl_q.tb_cnt[TB_W-1:0];
                    ctl_d.tb_cnt = ctl_q.tb_cnt + 1'b1;
                    ctl_d.cand   = '0;
                    ctl_d.st     = ST_SCAN;
                end
            end
            ST_SCAN: begin
                if (!pick_vld || ctl_q.cand == CAND_W'(MAX_CAND)) begin
                    ctl_d.st = ST_IDLE;
                end else begin
                    ctl_d.pend[pick_idx] = 1'b0;
                    ctl_d.cand           = ctl_q.cand + 1'b1;
                    if (match_vld) begin
                        ctl_d.unit = match_idx;
                        go         = 1'b1;
                    end else if (free_vld) begin
                        ctl_d.alloc[free_idx]                 = 1'b1;
                        ctl_d.unit_ch[free_idx*CH_W +: CH_W]  = pick_idx;
                        ctl_d.unit                            = free_idx;
                        go                                    = 1'b1;
                    end
                    if (go) begin
                        div_start  = 1'b1;
                        ctl_d.neg  = pick_neg;
                        ctl_d.qsum = pick_sum;
                        ctl_d.st   = ST_DIV;
                    end
                end
            end
            ST_DIV: begin
                if (div_done) ctl_d.st = ST_ACC;
            end
            ST_ACC: begin
                add_vec[ctl_q.unit] = 1'b1;
                ctl_d.st            = ST_SCAN;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
        if (event_start_i) begin
            ctl_d     = '0;
            ctl_d.st  = ST_IDLE;
            clr       = 1'b1;
            div_start = 1'b0;
            add_vec   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign y_acc = ctl_q.neg ? -$signed({1'b0, div_quo}) : $signed({1'b0, div_quo});

    logic [ACC_W-1:0] u_n   [NUM_UNITS];
    logic [ACC_W-1:0] u_sx  [NUM_UNITS];
    logic [ACC_W-1:0] u_sy  [NUM_UNITS];
    logic [ACC_W-1:0] u_sxy [NUM_UNITS];
    logic [ACC_W-1:0] u_sx2 [NUM_UNITS];
    logic [ACC_W-1:0] u_sy2 [NUM_UNITS];
    logic [ACC_W-1:0] u_sq  [NUM_UNITS];
    logic [NUM_UNITS-1:0] ovf_vec;

    for (genvar g = 0; g < NUM_UNITS; g++) begin : g_unit
        fit_sum_unit #(
            .ACC_W (ACC_W),
            .TB_W  (TB_W),
            .POS_W (POS_W),
            .SUM_W (SUM_W)
        ) u_sums (
            .clk   (clk),
            .rst_n (rst_n),
            .clr_i (clr),
            .add_i (add_vec[g]),
            .x_i   (ctl_q.x),
            .y_i   (y_acc),
            .q_i   (ctl_q.qsum),
            .n_o   (u_n[g]),
            .sx_o  (u_sx[g]),
            .sy_o  (u_sy[g]),
            .sxy_o (u_sxy[g]),
            .sx2_o (u_sx2[g]),
            .sy2_o (u_sy2[g]),
            .sq_o  (u_sq[g]),
            .ovf_o (ovf_vec[g])
        );
    end

    // read-only register file
    always_comb begin
        rd_data_o = '0;
        case (int'(rd_sel_i))
            SEL_N:   rd_data_o = u_n[rd_unit_i];
            SEL_SX:  rd_data_o = u_sx[rd_unit_i];
            SEL_SY:  rd_data_o = u_sy[rd_unit_i];
            SEL_SXY: rd_data_o = u_sxy[rd_unit_i];
            SEL_SX2: rd_data_o = u_sx2[rd_unit_i];
            SEL_SY2: rd_data_o = u_sy2[rd_unit_i];
            SEL_SQ:  rd_data_o = u_sq[rd_unit_i];
            default: begin
                rd_data_o[0]           = ovf_vec[rd_unit_i];
                rd_data_o[1]           = ctl_q.alloc[rd_unit_i];
                rd_data_o[2 +: CH_W]   = ctl_q.unit_ch[rd_unit_i*CH_W +: CH_W];
            end
        endcase
    end

    assign busy_o = (ctl_q.st != ST_IDLE);

    logic [TB_W:0]        tb_cnt_w;
    logic [CAND_W-1:0]    cand_w;
    logic [NUM_UNITS-1:0] alloc_w;
    assign tb_cnt_w = ctl_q.tb_cnt;
    assign cand_w   = ctl_q.cand;
    assign alloc_w  = ctl_q.alloc;

endmodule

// File: rtl/tracklet_fit_accum_chk.sv
module tracklet_fit_accum_chk #(
    parameter int NUM_UNITS = 4,
    parameter int TB_W      = 6,
    parameter int MAX_CAND  = 4,
    parameter int FRAC_W    = 6,
    localparam int CAND_W   = $clog2(MAX_CAND + 1)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 event_start_i,
    input logic                 tb_valid_i,
    input logic                 busy_i,
    input logic [TB_W:0]        tb_cnt_i,
    input logic [CAND_W-1:0]    cand_i,
    input logic [NUM_UNITS-1:0] alloc_i,
    input logic [NUM_UNITS-1:0] ovf_i
);

    localparam int NUM_TB   = 2 ** TB_W;
    localparam int BUSY_MAX = MAX_CAND * (FRAC_W + 3) + 1;

    logic [15:0] busy_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      busy_run <= '0;
        else if (busy_i) busy_run <= busy_run + 1'b1;
        else             busy_run <= '0;
    end

    p_cand_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cand_i) <= MAX_CAND);

    p_alloc_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_i & NUM_UNITS'(alloc_i + 1'b1)) == '0);

    p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !event_start_i |=> ((ovf_i & $past(ovf_i)) == $past(ovf_i)));

    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        event_start_i |=> (alloc_i == '0 && ovf_i == '0 && tb_cnt_i == '0 && !busy_i));

    p_tb_limit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        int'(tb_cnt_i) <= NUM_TB);

    p_full_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(tb_cnt_i) == NUM_TB && !busy_i && !event_start_i) |=> !busy_i);

    p_busy_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tb_valid_i && !busy_i && !event_start_i && int'(tb_cnt_i) < NUM_TB) |=> busy_i);

    p_busy_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        int'(busy_run) <= BUSY_MAX);

endmodule

bind tracklet_fit_accum tracklet_fit_accum_chk #(
    .NUM_UNITS (NUM_UNITS),
    .TB_W      (TB_W),
    .MAX_CAND  (MAX_CAND),
    .FRAC_W    (FRAC_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .event_start_i (event_start_i),
    .tb_valid_i    (tb_valid_i),
    .busy_i        (busy_o),
    .tb_cnt_i      (tb_cnt_w),
    .cand_i        (cand_w),
    .alloc_i       (alloc_w),
    .ovf_i         (ovf_vec)
);

// File: tb/tracklet_fit_accum_tb.sv
`timescale 1ns/1ps
module tracklet_fit_accum_tb;

    localparam int NCH   = 12;
    localparam int SW    = 10;
    localparam int NU    = 4;
    localparam int MAXC  = 4;
    localparam int TBW   = 6;
    localparam int FR    = 6;
    localparam int AW    = 16;
    localparam int NTB   = 64;
    localparam int BUSYB = MAXC * (FR + 3) + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          event_start = 1'b0;
    logic          tb_valid = 1'b0;
    logic [NCH*SW-1:0] samples = '0;
    logic [SW+1:0] thr = '0;
    logic [1:0]    rd_unit = '0;
    logic [2:0]    rd_sel = '0;
    logic [AW-1:0] rd_data;
    logic          busy;

    always #2.5 clk = ~clk;

    tracklet_fit_accum #(
        .NUM_CH(NCH), .SAMPLE_W(SW), .NUM_UNITS(NU), .MAX_CAND(MAXC),
        .TB_W(TBW), .FRAC_W(FR), .ACC_W(AW)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .event_start_i(event_start), .tb_valid_i(tb_valid),
        .samples_i(samples), .thr_i(thr), .rd_unit_i(rd_unit), .rd_sel_i(rd_sel),
        .rd_data_o(rd_data), .busy_o(busy)
    );

    int n_vec = 0;
    int n_fail = 0;
    bit done = 0;

    // reference model state
    int     m_thr;
    int     m_tb;
    int     m_ch [NU];
    bit     m_alloc [NU];
    bit     m_ovf [NU];
    longint m_s [NU][7];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        m_tb = 0;
        for (int u = 0; u < NU; u++) begin
            m_ch[u] = 0; m_alloc[u] = 0; m_ovf[u] = 0;
            for (int k = 0; k < 7; k++) m_s[u][k] = 0;
        end
    endtask

    task automatic model_add(input int u, input int k, input longint inc);
        longint v;
        v = m_s[u][k] + inc;
        if (k == 2 || k == 3) begin
            if (v > 32767)  begin v = 32767;  m_ovf[u] = 1; end
            if (v < -32768) begin v = -32768; m_ovf[u] = 1; end
        end else begin
            if (v > 65535) begin v = 65535; m_ovf[u] = 1; end
        end
        m_s[u][k] = v;
    endtask

    // R1 hit rule, R2 ordering/limit, R3 allocation, R4 position, R5 sums
    task automatic model_tb(input int s[NCH]);
        int x, cand, u, l, c, r, q, y;
        if (m_tb >= NTB) return;
        x = m_tb;
        m_tb++;
        cand = 0;
        for (int ch = 1; ch < NCH - 1; ch++) begin
            if (cand == MAXC) break;
            l = s[ch-1]; c = s[ch]; r = s[ch+1]; q = l + c + r;
            if (c > l && c > r && q > m_thr) begin
                cand++;
                u = -1;
                for (int k = 0; k < NU; k++) if (m_alloc[k] && m_ch[k] == ch && u < 0) u = k;
                if (u < 0) begin
                    for (int k = 0; k < NU; k++) if (!m_alloc[k] && u < 0) u = k;
                    if (u >= 0) begin m_alloc[u] = 1; m_ch[u] = ch; end
                end
                if (u >= 0) begin
                    y = ((r - l) * 64) / q;
                    model_add(u, 0, 1);
                    model_add(u, 1, x);
                    model_add(u, 2, y);
                    model_add(u, 3, x * y);
                    model_add(u, 4, x * x);
                    model_add(u, 5, y * y);
                    model_add(u, 6, q);
                end
            end
        end
    endtask

    // R9 read port: every select of every unit
    task automatic check_all(input string tag);
        logic [AW-1:0] exp;
        for (int u = 0; u < NU; u++) begin
            for (int sel = 0; sel < 8; sel++) begin
                rd_unit = 2'(u);
                rd_sel  = 3'(sel);
                #1;
                if (sel < 7) exp = AW'(m_s[u][sel]);
                else         exp = AW'({m_ch[u][3:0], m_alloc[u], m_ovf[u]});
                chk($sformatf("%s unit%0d sel%0d (R9)", tag, u, sel), 32'(rd_data), 32'(exp));
            end
        end
    endtask

    task automatic start_event(input int t);
        @(negedge clk);
        thr = 12'(t);
        m_thr = t;
        event_start = 1'b1;
        @(negedge clk);
        event_start = 1'b0;
        model_clear();
    endtask

    task automatic drive_samples(input int s[NCH]);
        for (int i = 0; i < NCH; i++) samples[i*SW +: SW] = SW'(s[i]);
    endtask

    task automatic do_tb(input int s[NCH], input string tag);
        bit acc;
        int cnt;
        acc = (m_tb < NTB);
        @(negedge clk);
        drive_samples(s);
        tb_valid = 1'b1;
        @(negedge clk);
        tb_valid = 1'b0;
        chk({tag, " busy after tb (R10/R8)"}, 32'(busy), 32'(acc));
        cnt = 0;
        while (busy && cnt < 1000) begin
            cnt++;
            @(negedge clk);
        end
        chk({tag, " busy length bound (R10)"}, 32'(cnt <= BUSYB), 32'd1);
        model_tb(s);
        check_all(tag);
    endtask

    int smp [NCH];

    task automatic zero_smp();
        for (int i = 0; i < NCH; i++) smp[i] = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R10 watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        model_clear();
        m_thr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("reset busy (R10)", 32'(busy), 32'd0);
        check_all("reset R7");

        // R1: threshold and strict-peak boundaries at centre 4
        start_event(100);
        zero_smp(); smp[3] = 30; smp[4] = 40; smp[5] = 30;   // sum == thr: no hit
        do_tb(smp, "R1 sum equal thr");
        zero_smp(); smp[3] = 30; smp[4] = 40; smp[5] = 31;   // sum thr+1: hit
        do_tb(smp, "R1 sum above thr");
        zero_smp(); smp[3] = 40; smp[4] = 40; smp[5] = 30;   // centre equals left: no hit
        do_tb(smp, "R1 equal neighbour");
        zero_smp(); smp[0] = 900; smp[1] = 10; smp[11] = 900; smp[10] = 10; // edges
        do_tb(smp, "R1 edge channels");
        zero_smp(); smp[3] = 300; smp[4] = 301; smp[5] = 0;  // negative y, R4
        do_tb(smp, "R4 negative position");

        // R2: five peaks in one timebin, fifth dropped
        start_event(0);
        zero_smp();
        for (int p = 1; p < 10; p += 2) begin smp[p] = 100 + p; smp[p-1] = 10; smp[p+1] = 10; end
        do_tb(smp, "R2 five peaks");
        // R3: unit pool exhausted, centre 9 ignored; existing channels reuse units
        zero_smp(); smp[8] = 5; smp[9] = 200; smp[10] = 7;
        do_tb(smp, "R3 no free unit");
        zero_smp(); smp[2] = 1; smp[3] = 500; smp[4] = 2; smp[5] = 600; smp[6] = 9;
        do_tb(smp, "R3 reuse units");

        // R8: tb_valid while busy is ignored
        zero_smp(); smp[6] = 11; smp[7] = 400; smp[8] = 3;
        @(negedge clk);
        drive_samples(smp);
        tb_valid = 1'b1;
        @(negedge clk);
        zero_smp(); smp[2] = 0; smp[3] = 800; smp[4] = 0;
        drive_samples(smp);
        @(negedge clk);
        tb_valid = 1'b0;
        while (busy) @(negedge clk);
        zero_smp(); smp[6] = 11; smp[7] = 400; smp[8] = 3;
        model_tb(smp);
        check_all("R8 busy ignore");

        // R7: clear mid-event
        start_event(0);
        check_all("R7 cleared");

        // R4/R5 sweep: random events, several thresholds
        for (int e = 0; e < 4; e++) begin
            start_event(e * 400);
            for (int t = 0; t < 40; t++) begin
                for (int i = 0; i < NCH; i++) smp[i] = int'($urandom % 1024);
                do_tb(smp, "R5 random");
            end
        end

        // R6 saturation with two opposite-signed peaks over the full event, then R8 limit
        start_event(0);
        for (int t = 0; t < NTB; t++) begin
            zero_smp();
            smp[1] = 1022; smp[2] = 1023; smp[3] = 0;
            smp[5] = 0;    smp[6] = 1023; smp[7] = 1000;
            do_tb(smp, "R6 saturate");
        end
        rd_unit = 2'd1; rd_sel = 3'd6; #1;
        chk("R6 charge sum clamped", 32'(rd_data), 32'hFFFF);
        rd_unit = 2'd0; rd_sel = 3'd3; #1;
        chk("R6 signed xy clamped", 32'(rd_data), 32'h8000);
        do_tb(smp, "R8 beyond last timebin");

        start_event(0);
        check_all("R7 clears overflow");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule